// File: doc/BRIEF.md
# Affine-Gap Local Alignment Cell

This block is one scoring element of a systolic array for local sequence alignment with affine gap costs. Each element owns one cell of the alignment matrix. It receives the residue codes of its row and column and the gap scores from its neighbours. It also receives the diagonal H score from a delay buffer, plus the gap-open and gap-extend costs. From these it produces its own E, F and H scores, which its neighbours read.

The element works in two alternating clock phases that it sequences itself. The phase register is cleared by reset and toggles on every clock after that. In the first phase the two gap scores are registered. In the second phase the cell score is formed from those registered gap scores and the diagonal term plus the pair weight, and is floored at zero. In the same edge the element raises its running maximum of H when the new H is larger. The surrounding array reads the maximum as the row's best local score.

Top module: `sw_affine_cell`

## Requirements
- R1: While `rst_n` is low at a clock edge, E, F, H, the running maximum and the phase are all cleared to zero.
- R2: At each gap-phase edge (`h_phase` low), `e_out` loads max(`e_in` − `gap_ext`, `h_row_in` − `gap_open`), as a 12-bit signed value.
- R3: At each gap-phase edge, `f_out` loads max(`f_in` − `gap_ext`, `h_col_in` − `gap_open`).
- R4: At each score-phase edge (`h_phase` high), `h_out` loads the largest of 0, the registered E, the registered F, and `h_diag_in` plus the pair weight.
- R5: The pair weight is +2 when the 2-bit codes `res_a` and `res_b` are equal, and −1 when they differ.
- R6: `h_phase` is 0 in the first cycle after reset and alternates every cycle. E and F change only at gap-phase edges. H and the maximum change only at score-phase edges.
- R7: `max_h` never decreases, is never below `h_out`, and equals the largest H produced since reset.
- R8: `h_out` is never negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_a | input | 2 | Residue code of the row sequence |
| res_b | input | 2 | Residue code of the column sequence |
| e_in | input | 12 | Signed E score from the left neighbour |
| f_in | input | 12 | Signed F score from the upper neighbour |
| h_row_in | input | 12 | Signed H score from the left neighbour |
| h_col_in | input | 12 | Signed H score from the upper neighbour |
| h_diag_in | input | 12 | Signed diagonal H score from the buffer |
| gap_open | input | 11 | Unsigned gap-open cost |
| gap_ext | input | 11 | Unsigned gap-extend cost |
| h_phase | output | 1 | High in the cycle whose closing edge loads H |
| e_out | output | 12 | Registered E score |
| f_out | output | 12 | Registered F score |
| h_out | output | 12 | Registered H score |
| max_h | output | 12 | Running maximum of H since reset |

## Verification
The E and F results are due one edge after the stimulus is applied in a gap-phase cycle. H and the maximum are due one edge later, at the score-phase edge. The bench releases reset on a falling edge, so it knows the phase of every following edge. It drives each stimulus on a falling edge before a gap-phase edge and holds it through the next score-phase edge. It reads E, F and an unchanged H on the falling edge between the two rising edges. It reads H and the maximum on the falling edge after the second one. The residue pairs are swept exhaustively against a spread of scores and costs, including cases where every term is negative.

// File: rtl/sw_cell_pkg.sv
// Package: shared helpers for the alignment cell.
// Assumes scores are two's-complement values of equal width.
package sw_cell_pkg;

    // Signed maximum of two equal-width scores.
    function automatic logic signed [11:0] smax12(input logic signed [11:0] x,
                                                  input logic signed [11:0] y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/sw_pair_weight.sv
// Module: pair weight lookup.
// Gives MATCH_W when the two residue codes are equal, else MISMATCH_W.
// Assumes both weights fit in W signed bits.
module sw_pair_weight #(
    parameter int W          = 12,
    parameter int CW         = 2,
    parameter int MATCH_W    = 2,
    parameter int MISMATCH_W = -1
) (
    input  logic [CW-1:0]       code_a,
    input  logic [CW-1:0]       code_b,
    output logic signed [W-1:0] weight
);
    localparam logic signed [W-1:0] MW = W'(MATCH_W);
    localparam logic signed [W-1:0] XW = W'(MISMATCH_W);

    // Choose the weight from the code comparison.
    always_comb weight = (code_a == code_b) ? MW : XW;
endmodule

// File: rtl/sw_gap_reg.sv
// Module: one affine gap score register (used for both E and F).
// Loads max(prev - extend, h - open) when ld is high, else holds.
// Assumes costs are non-negative and scores stay inside W bits.
module sw_gap_reg #(
    parameter int W  = 12,
    parameter int PW = W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld,
    input  logic signed [W-1:0] prev_gap,
    input  logic signed [W-1:0] h_src,
    input  logic [PW-1:0]       open_cost,
    input  logic [PW-1:0]       ext_cost,
    output logic signed [W-1:0] q
);
    logic signed [W-1:0] ext_path, open_path, nxt;

    // Form both candidate gap scores and pick the larger.
    always_comb begin
        ext_path  = prev_gap - $signed({{(W-PW){1'b0}}, ext_cost});
        open_path = h_src    - $signed({{(W-PW){1'b0}}, open_cost});
        nxt       = (ext_path > open_path) ? ext_path : open_path;
    end

    // Register the gap score in its load phase.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= nxt;
    end
endmodule

// File: rtl/sw_score_reg.sv
// Module: cell score H and running maximum.
// On ld, H takes the largest of 0, E, F and diag+weight, and the maximum
// is raised to the new H when that is larger. Assumes no overflow.
module sw_score_reg #(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld,
    input  logic signed [W-1:0] e_val,
    input  logic signed [W-1:0] f_val,
    input  logic signed [W-1:0] diag,
    input  logic signed [W-1:0] weight,
    output logic signed [W-1:0] h,
    output logic signed [W-1:0] hmax
);
    logic signed [W-1:0] diag_sum, best_gap, best_any, h_nxt;

    // Combine the three candidates and floor the result at zero.
    always_comb begin
        diag_sum = diag + weight;
        best_gap = (e_val > f_val) ? e_val : f_val;
        best_any = (best_gap > diag_sum) ? best_gap : diag_sum;
        h_nxt    = (best_any > 0) ? best_any : '0;
    end

    // Register H and raise the running maximum in the score phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h    <= '0;
            hmax <= '0;
        end else if (ld) begin
            h <= h_nxt;
            if (h_nxt > hmax) hmax <= h_nxt;
        end
    end

    assert_h_nonneg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        h >= 0);
    assert_max_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> hmax >= $past(hmax));
    assert_max_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hmax >= h);
endmodule

// File: rtl/sw_affine_cell.sv
// Module: affine-gap local alignment cell (top).
// Sequences two phases: a gap phase that registers E and F, then a score
// phase that registers H and the running maximum. Inputs are expected to
// be held across both phases of one cell update.
module sw_affine_cell #(
    parameter int W          = 12,
    parameter int CW         = 2,
    parameter int MATCH_W    = 2,
    parameter int MISMATCH_W = -1,
    parameter int PW         = W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CW-1:0]       res_a,
    input  logic [CW-1:0]       res_b,
    input  logic signed [W-1:0] e_in,
    input  logic signed [W-1:0] f_in,
    input  logic signed [W-1:0] h_row_in,
    input  logic signed [W-1:0] h_col_in,
    input  logic signed [W-1:0] h_diag_in,
    input  logic [PW-1:0]       gap_open,
    input  logic [PW-1:0]       gap_ext,
    output logic                h_phase,
    output logic signed [W-1:0] e_out,
    output logic signed [W-1:0] f_out,
    output logic signed [W-1:0] h_out,
    output logic signed [W-1:0] max_h
);
    logic signed [W-1:0] pair_w;

    // Alternate between the gap phase (0) and the score phase (1).
    always_ff @(posedge clk) begin
        if (!rst_n) h_phase <= 1'b0;
        else        h_phase <= ~h_phase;
    end

    sw_pair_weight #(.W(W), .CW(CW), .MATCH_W(MATCH_W), .MISMATCH_W(MISMATCH_W))
        u_weight (.code_a(res_a), .code_b(res_b), .weight(pair_w));

    sw_gap_reg #(.W(W), .PW(PW)) u_e (
        .clk(clk), .rst_n(rst_n), .ld(~h_phase), .prev_gap(e_in),
        .h_src(h_row_in), .open_cost(gap_open), .ext_cost(gap_ext), .q(e_out));

    sw_gap_reg #(.W(W), .PW(PW)) u_f (
        .clk(clk), .rst_n(rst_n), .ld(~h_phase), .prev_gap(f_in),
        .h_src(h_col_in), .open_cost(gap_open), .ext_cost(gap_ext), .q(f_out));

    sw_score_reg #(.W(W)) u_h (
        .clk(clk), .rst_n(rst_n), .ld(h_phase), .e_val(e_out), .f_val(f_out),
        .diag(h_diag_in), .weight(pair_w), .h(h_out), .hmax(max_h));

    assert_phase_alt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> h_phase != $past(h_phase));
    assert_h_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !h_phase |=> $stable(h_out) && $stable(max_h));
    assert_ef_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        h_phase |=> $stable(e_out) && $stable(f_out));
    assert_weight_R5: assert property (@(posedge clk)
        (res_a == res_b) ? (pair_w > 0) : (pair_w <= 0));
endmodule

// File: tb/test_sw_affine_cell.sv
module test_sw_affine_cell;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] res_a = '0, res_b = '0;
    logic signed [11:0] e_in = '0, f_in = '0, h_row_in = '0, h_col_in = '0, h_diag_in = '0;
    logic [10:0] gap_open = '0, gap_ext = '0;
    logic h_phase;
    logic signed [11:0] e_out, f_out, h_out, max_h;

    int n_chk = 0, n_bad = 0;
    int m_max = 0, m_h = 0;

    always #4 clk = ~clk;

    sw_affine_cell i_sw_affine_cell (
        .clk(clk), .rst_n(rst_n), .res_a(res_a), .res_b(res_b),
        .e_in(e_in), .f_in(f_in), .h_row_in(h_row_in), .h_col_in(h_col_in),
        .h_diag_in(h_diag_in), .gap_open(gap_open), .gap_ext(gap_ext),
        .h_phase(h_phase), .e_out(e_out), .f_out(f_out), .h_out(h_out), .max_h(max_h));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    // One full cell update with checks at both phases.
    task automatic run_cell(input int a, input int b, input int ei, input int fi,
                            input int hr, input int hc, input int hd,
                            input int go, input int ge);
        int ee, ef, w, eh;
        res_a = 2'(a); res_b = 2'(b);
        e_in = 12'(ei); f_in = 12'(fi); h_row_in = 12'(hr); h_col_in = 12'(hc);
        h_diag_in = 12'(hd); gap_open = 11'(go); gap_ext = 11'(ge);
        ee = imax(ei - ge, hr - go);
        ef = imax(fi - ge, hc - go);
        w  = (a == b) ? 2 : -1;           // R5 pair weight
        eh = imax(0, imax(imax(ee, ef), hd + w));
        chk("R6 gap phase", int'(h_phase), 0);
        @(posedge clk); @(negedge clk);
        chk("R2 E", int'(e_out), ee);
        chk("R3 F", int'(f_out), ef);
        chk("R6 H held", int'(h_out), m_h);
        chk("R6 phase", int'(h_phase), 1);
        @(posedge clk); @(negedge clk);
        chk("R4 H", int'(h_out), eh);
        chk("R8 H sign", int'(h_out < 0), 0);
        chk("R6 E held", int'(e_out), ee);
        m_h = eh;
        m_max = imax(m_max, eh);
        chk("R7 max", int'(max_h), m_max);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 E", int'(e_out), 0);
        chk("R1 F", int'(f_out), 0);
        chk("R1 H", int'(h_out), 0);
        chk("R1 max", int'(max_h), 0);
        chk("R1 phase", int'(h_phase), 0);
        rst_n = 1'b1;
        // Exhaustive residue pairs against a spread of scores.
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int k = 0; k < 12; k++)
                    run_cell(a, b, (k*37 % 201) - 100, (k*53 % 201) - 100,
                             (k*29 % 201) - 100, (k*71 % 201) - 100,
                             (k*43 % 151) + 4*a + b, k*7 % 31, k*3 % 16);
        // All terms negative: H floors at zero (R4, R8).
        run_cell(1, 2, -300, -300, -200, -200, 0, 20, 5);
        chk("R4 floor", int'(h_out), 0);
        // Large diagonal match raises the maximum (R7).
        run_cell(3, 3, 0, 0, 0, 0, 500, 10, 1);
        // Smaller score later leaves the maximum unchanged (R7).
        run_cell(0, 1, 0, 0, 0, 0, 50, 10, 1);
        // Reset mid-run clears everything again (R1).
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 E again", int'(e_out), 0);
        chk("R1 H again", int'(h_out), 0);
        chk("R1 max again", int'(max_h), 0);
        chk("R1 phase again", int'(h_phase), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule